// File: doc/BRIEF.md
# Multilevel Cache Miss Lookup Sequencer

This block serves one core of a multicore cluster. When a core data request misses in its first-level cache, the sequencer takes it and walks the on-chip lookup levels in a fixed order. It issues one lookup at a time and waits for that level's hit/miss answer. It then returns the data together with a code that names the level which supplied it. The levels are the core's private second-level tags, the shared last-level cache and the other cores' private caches (a peer snoop). Main memory is read only after all of them have missed.

A mode input sets the shared-cache policy. With an exclusive shared cache, a line missing there may still sit in another core's private cache, so a shared miss leads to a peer snoop. With an inclusive shared cache, a shared miss proves that no other core holds the line, so the sequencer goes straight to memory. The mode is captured when a request is accepted. The sequencer holds only one request at a time. It keeps a saturating count of the snoops it has issued, so the cost of each policy can be compared.

Top module: `mlseq_top`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, no lookup strobe is high and `snoop_count` is 0.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 from the next cycle until the cycle after the response pulse, so only one request is outstanding.
- R3: The private-level lookup is the first lookup of every request. It is issued exactly once, as a one-cycle strobe in the cycle after acceptance.
- R4: A private hit returns source code 0 and the private-level data. No further lookup is issued.
- R5: A private miss issues one shared-level lookup. A shared hit returns source code 1 and the shared-level data.
- R6: In exclusive mode (`excl_mode` = 1), a shared miss issues one peer snoop. A snoop hit returns source code 2 and the peer data.
- R7: In inclusive mode (`excl_mode` = 0), a shared miss issues no snoop and goes directly to the memory read.
- R8: The memory read is issued only in the cycle after a shared miss (inclusive mode) or a snoop miss (exclusive mode). It returns source code 3 and the memory data.
- R9: `snoop_count` increases by one for each snoop strobe and saturates at its all-ones value.
- R10: `excl_mode` is sampled when the request is accepted. Changes to it while the request is in flight have no effect on that request.
- R11: At most one of the four lookup strobes is high in any cycle.
- R12: `resp_valid` is a single-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| excl_mode | input | 1 | 1 = exclusive shared cache, 0 = inclusive |
| req_valid | input | 1 | Miss request from the core |
| req_addr | input | AW | Request address |
| req_ready | output | 1 | Sequencer idle, can accept a request |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_src | output | 2 | Source code: 0 private, 1 shared, 2 peer, 3 memory |
| resp_data | output | DW | Returned data |
| priv_lkp_valid | output | 1 | Private-level lookup strobe |
| priv_lkp_addr | output | AW | Private-level lookup address |
| priv_rsp_valid | input | 1 | Private-level answer strobe |
| priv_rsp_hit | input | 1 | Private-level hit |
| priv_rsp_data | input | DW | Private-level data |
| shrd_lkp_valid | output | 1 | Shared-level lookup strobe |
| shrd_lkp_addr | output | AW | Shared-level lookup address |
| shrd_rsp_valid | input | 1 | Shared-level answer strobe |
| shrd_rsp_hit | input | 1 | Shared-level hit |
| shrd_rsp_data | input | DW | Shared-level data |
| snp_lkp_valid | output | 1 | Peer snoop strobe |
| snp_lkp_addr | output | AW | Peer snoop address |
| snp_rsp_valid | input | 1 | Peer snoop answer strobe |
| snp_rsp_hit | input | 1 | Peer snoop hit |
| snp_rsp_data | input | DW | Peer data |
| mem_rd_valid | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory data strobe |
| mem_rsp_data | input | DW | Memory data |
| snoop_count | output | CW | Saturating count of snoops issued |

## Verification
The assertions assume the following about each lookup port. It answers only a lookup that is outstanding, with exactly one answer strobe. That answer comes at least one cycle after the lookup strobe, never in the same cycle. The memory port is assumed always to return data. The bench meets these assumptions with fixed-latency responders: private 1 cycle, shared 3, peer 4, memory 6. Each responder arms only on its own lookup strobe and raises its answer strobe for exactly one cycle. The hit pattern is held stable for the whole request. The bench sweeps every hit pattern in both modes, flips the mode while requests are in flight, and issues enough snoops to reach saturation.

// File: rtl/mlseq_pkg.sv
package mlseq_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRIV,
        PH_SHRD,
        PH_PEER,
        PH_MEM,
        PH_RESP
    } phase_e;

    localparam logic [1:0] SRC_PRIV = 2'd0;
    localparam logic [1:0] SRC_SHRD = 2'd1;
    localparam logic [1:0] SRC_PEER = 2'd2;
    localparam logic [1:0] SRC_MEM  = 2'd3;
endpackage

// File: rtl/mlseq_sat_ctr.sv
module mlseq_sat_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] CMAX = '1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (inc && cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    assert_ctr_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inc) && $past(count) != CMAX |-> count == $past(count) + 1'b1);
    assert_ctr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(inc) |-> $stable(count));
endmodule

// File: rtl/mlseq_ctrl.sv
module mlseq_ctrl
    import mlseq_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          excl_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [1:0]    resp_src,
    output logic [DW-1:0] resp_data,
    output logic          priv_lkp_valid,
    output logic [AW-1:0] priv_lkp_addr,
    input  logic          priv_rsp_valid,
    input  logic          priv_rsp_hit,
    input  logic [DW-1:0] priv_rsp_data,
    output logic          shrd_lkp_valid,
    output logic [AW-1:0] shrd_lkp_addr,
    input  logic          shrd_rsp_valid,
    input  logic          shrd_rsp_hit,
    input  logic [DW-1:0] shrd_rsp_data,
    output logic          snp_lkp_valid,
    output logic [AW-1:0] snp_lkp_addr,
    input  logic          snp_rsp_valid,
    input  logic          snp_rsp_hit,
    input  logic [DW-1:0] snp_rsp_data,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data
);
    typedef struct packed {
        phase_e        ph;
        logic          issue;
        logic          excl;
        logic [AW-1:0] addr;
        logic [1:0]    src;
        logic [DW-1:0] data;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.issue = 1'b0;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.ph    = PH_PRIV;
                    s_d.addr  = req_addr;
                    s_d.excl  = excl_mode;
                    s_d.issue = 1'b1;
                end
            end
            PH_PRIV: begin
                if (!s_q.issue && priv_rsp_valid) begin
                    if (priv_rsp_hit) begin
                        s_d.ph   = PH_RESP;
                        s_d.src  = SRC_PRIV;
                        s_d.data = priv_rsp_data;
                    end else begin
                        s_d.ph    = PH_SHRD;
                        s_d.issue = 1'b1;
                    end
                end
            end
            PH_SHRD: begin
                if (!s_q.issue && shrd_rsp_valid) begin
                    if (shrd_rsp_hit) begin
                        s_d.ph   = PH_RESP;
                        s_d.src  = SRC_SHRD;
                        s_d.data = shrd_rsp_data;
                    end else begin
                        s_d.ph    = s_q.excl ? PH_PEER : PH_MEM;
                        s_d.issue = 1'b1;
                    end
                end
            end
            PH_PEER: begin
                if (!s_q.issue && snp_rsp_valid) begin
                    if (snp_rsp_hit) begin
                        s_d.ph   = PH_RESP;
                        s_d.src  = SRC_PEER;
                        s_d.data = snp_rsp_data;
                    end else begin
                        s_d.ph    = PH_MEM;
                        s_d.issue = 1'b1;
                    end
                end
            end
            PH_MEM: begin
                if (!s_q.issue && mem_rsp_valid) begin
                    s_d.ph   = PH_RESP;
                    s_d.src  = SRC_MEM;
                    s_d.data = mem_rsp_data;
                end
            end
            PH_RESP: s_d.ph = PH_IDLE;
            default: s_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.ph    <= PH_IDLE;
            s_q.issue <= 1'b0;
            s_q.excl  <= 1'b0;
            s_q.addr  <= '0;
            s_q.src   <= '0;
            s_q.data  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign req_ready      = (s_q.ph == PH_IDLE);
    assign resp_valid     = (s_q.ph == PH_RESP);
    assign resp_src       = s_q.src;
    assign resp_data      = s_q.data;
    assign priv_lkp_valid = (s_q.ph == PH_PRIV) && s_q.issue;
    assign shrd_lkp_valid = (s_q.ph == PH_SHRD) && s_q.issue;
    assign snp_lkp_valid  = (s_q.ph == PH_PEER) && s_q.issue;
    assign mem_rd_valid   = (s_q.ph == PH_MEM)  && s_q.issue;
    assign priv_lkp_addr  = s_q.addr;
    assign shrd_lkp_addr  = s_q.addr;
    assign snp_lkp_addr   = s_q.addr;
    assign mem_rd_addr    = s_q.addr;

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);
    assert_priv_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        priv_lkp_valid |-> $past(req_valid && req_ready));
    assert_shrd_after_priv_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shrd_lkp_valid |-> $past(priv_rsp_valid && !priv_rsp_hit));
    assert_snoop_only_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        snp_lkp_valid |-> $past(shrd_rsp_valid && !shrd_rsp_hit) && s_q.excl);
    assert_mem_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> $past(shrd_rsp_valid && !shrd_rsp_hit) ||
                         $past(snp_rsp_valid && !snp_rsp_hit));
    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({priv_lkp_valid, shrd_lkp_valid, snp_lkp_valid, mem_rd_valid}));
    assert_resp_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid && req_ready);
endmodule

// File: rtl/mlseq_top.sv
module mlseq_top #(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          excl_mode,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    output logic          req_ready,
    output logic          resp_valid,
    output logic [1:0]    resp_src,
    output logic [DW-1:0] resp_data,
    output logic          priv_lkp_valid,
    output logic [AW-1:0] priv_lkp_addr,
    input  logic          priv_rsp_valid,
    input  logic          priv_rsp_hit,
    input  logic [DW-1:0] priv_rsp_data,
    output logic          shrd_lkp_valid,
    output logic [AW-1:0] shrd_lkp_addr,
    input  logic          shrd_rsp_valid,
    input  logic          shrd_rsp_hit,
    input  logic [DW-1:0] shrd_rsp_data,
    output logic          snp_lkp_valid,
    output logic [AW-1:0] snp_lkp_addr,
    input  logic          snp_rsp_valid,
    input  logic          snp_rsp_hit,
    input  logic [DW-1:0] snp_rsp_data,
    output logic          mem_rd_valid,
    output logic [AW-1:0] mem_rd_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic [CW-1:0] snoop_count
);
    mlseq_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .excl_mode      (excl_mode),
        .req_valid      (req_valid),
        .req_addr       (req_addr),
        .req_ready      (req_ready),
        .resp_valid     (resp_valid),
        .resp_src       (resp_src),
        .resp_data      (resp_data),
        .priv_lkp_valid (priv_lkp_valid),
        .priv_lkp_addr  (priv_lkp_addr),
        .priv_rsp_valid (priv_rsp_valid),
        .priv_rsp_hit   (priv_rsp_hit),
        .priv_rsp_data  (priv_rsp_data),
        .shrd_lkp_valid (shrd_lkp_valid),
        .shrd_lkp_addr  (shrd_lkp_addr),
        .shrd_rsp_valid (shrd_rsp_valid),
        .shrd_rsp_hit   (shrd_rsp_hit),
        .shrd_rsp_data  (shrd_rsp_data),
        .snp_lkp_valid  (snp_lkp_valid),
        .snp_lkp_addr   (snp_lkp_addr),
        .snp_rsp_valid  (snp_rsp_valid),
        .snp_rsp_hit    (snp_rsp_hit),
        .snp_rsp_data   (snp_rsp_data),
        .mem_rd_valid   (mem_rd_valid),
        .mem_rd_addr    (mem_rd_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_data   (mem_rsp_data)
    );

    mlseq_sat_ctr #(.CW(CW)) u_snoop_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (snp_lkp_valid),
        .count (snoop_count)
    );
endmodule

// File: tb/mlseq_top_tb.sv
module mlseq_top_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int CW = 4;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, excl_mode, req_valid, req_ready, resp_valid;
    logic [AW-1:0] req_addr;
    logic [1:0] resp_src;
    logic [DW-1:0] resp_data;
    logic [AW-1:0] lk_addr [4];
    logic lk_v [4];
    logic rv [4];
    logic [DW-1:0] rd [4];
    logic [CW-1:0] snoop_count;
    logic [2:0] hit_pat;

    mlseq_top #(.AW(AW), .DW(DW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .excl_mode(excl_mode),
        .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_src(resp_src), .resp_data(resp_data),
        .priv_lkp_valid(lk_v[0]), .priv_lkp_addr(lk_addr[0]),
        .priv_rsp_valid(rv[0]), .priv_rsp_hit(hit_pat[0]), .priv_rsp_data(rd[0]),
        .shrd_lkp_valid(lk_v[1]), .shrd_lkp_addr(lk_addr[1]),
        .shrd_rsp_valid(rv[1]), .shrd_rsp_hit(hit_pat[1]), .shrd_rsp_data(rd[1]),
        .snp_lkp_valid(lk_v[2]), .snp_lkp_addr(lk_addr[2]),
        .snp_rsp_valid(rv[2]), .snp_rsp_hit(hit_pat[2]), .snp_rsp_data(rd[2]),
        .mem_rd_valid(lk_v[3]), .mem_rd_addr(lk_addr[3]),
        .mem_rsp_valid(rv[3]), .mem_rsp_data(rd[3]),
        .snoop_count(snoop_count)
    );

    function automatic logic [DW-1:0] lvl_data(input int lvl, input logic [AW-1:0] a);
        return a ^ (32'h1111_1111 * (lvl + 1));
    endfunction

    int lat [4] = '{1, 3, 4, 6};
    int pend [4];
    int n_lk [4];
    logic [AW-1:0] cap [4];

    initial begin
        for (int i = 0; i < 4; i++) begin
            pend[i] = 0; n_lk[i] = 0; rv[i] = 1'b0; rd[i] = '0; cap[i] = '0;
        end
    end

    always @(negedge clk) begin
        for (int i = 0; i < 4; i++) begin
            rv[i] = 1'b0;
            if (pend[i] > 0) begin
                pend[i] = pend[i] - 1;
                if (pend[i] == 0) begin
                    rv[i] = 1'b1;
                    rd[i] = lvl_data(i, cap[i]);
                end
            end
            if (rst_n && lk_v[i]) begin
                pend[i] = lat[i];
                cap[i]  = lk_addr[i];
                n_lk[i] = n_lk[i] + 1;
            end
        end
    end

    int n_chk = 0;
    int n_fail = 0;
    int snoops_total = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_req(input logic [AW-1:0] a, input bit ex, input bit [2:0] pat,
                           input bit flip);
        int base [4];
        int wait_n;
        bit ready_low;
        logic [1:0] e_src;
        int e_snp;
        hit_pat = pat;
        for (int i = 0; i < 4; i++) base[i] = n_lk[i];
        @(negedge clk);
        chk(req_ready == 1'b1, "R2", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_addr = a; excl_mode = ex;
        @(negedge clk);
        req_valid = 1'b0;
        if (flip) excl_mode = ~ex;
        chk(lk_v[0] == 1'b1, "R3", "private strobe after accept", lk_v[0], 1);
        ready_low = 1'b1;
        wait_n = 0;
        while (!resp_valid && wait_n < 100) begin
            if (req_ready) ready_low = 1'b0;
            @(negedge clk);
            wait_n++;
        end
        chk(ready_low, "R2", "ready low while busy", ready_low, 1);
        chk(resp_valid == 1'b1, "R12", "response arrives", resp_valid, 1);
        e_src = pat[0] ? 2'd0 : pat[1] ? 2'd1 : (ex && pat[2]) ? 2'd2 : 2'd3;
        e_snp = (!pat[0] && !pat[1] && ex) ? 1 : 0;
        snoops_total += e_snp;
        case (e_src)
            2'd0: chk(resp_src == e_src, "R4", "src", resp_src, e_src);
            2'd1: chk(resp_src == e_src, "R5", "src", resp_src, e_src);
            2'd2: chk(resp_src == e_src, "R6", "src", resp_src, e_src);
            default: chk(resp_src == e_src, "R8", "src", resp_src, e_src);
        endcase
        chk(resp_data == lvl_data(int'(e_src), a), "R4", "data of source level",
            resp_data, lvl_data(int'(e_src), a));
        chk(n_lk[0] - base[0] == 1, "R3", "private lookups", n_lk[0] - base[0], 1);
        chk(n_lk[1] - base[1] == (pat[0] ? 0 : 1), "R5", "shared lookups",
            n_lk[1] - base[1], pat[0] ? 0 : 1);
        if (flip)
            chk(n_lk[2] - base[2] == e_snp, "R10", "snoops after mode flip",
                n_lk[2] - base[2], e_snp);
        else if (ex)
            chk(n_lk[2] - base[2] == e_snp, "R6", "snoops", n_lk[2] - base[2], e_snp);
        else
            chk(n_lk[2] - base[2] == 0, "R7", "no snoop inclusive", n_lk[2] - base[2], 0);
        chk(n_lk[3] - base[3] == (e_src == 2'd3 ? 1 : 0), "R8", "memory reads",
            n_lk[3] - base[3], e_src == 2'd3 ? 1 : 0);
        @(negedge clk);
        chk(resp_valid == 1'b0, "R12", "response one cycle", resp_valid, 0);
        chk(req_ready == 1'b1, "R2", "ready after response", req_ready, 1);
        chk(int'(snoop_count) == (snoops_total > CMAX ? CMAX : snoops_total), "R9",
            "snoop count", snoop_count, snoops_total > CMAX ? CMAX : snoops_total);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; excl_mode = 1'b0; hit_pat = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "reset ready", req_ready, 1);
        chk(resp_valid == 1'b0, "R1", "reset resp_valid", resp_valid, 0);
        chk(snoop_count == '0, "R1", "reset snoop_count", snoop_count, 0);
        chk(!(lk_v[0] | lk_v[1] | lk_v[2] | lk_v[3]), "R1", "reset strobes", 0, 0);
        for (int m = 0; m < 2; m++)
            for (int p = 0; p < 8; p++)
                for (int k = 0; k < 2; k++)
                    run_req(32'h0040_0000 + p * 32'h40 + k * 32'h1234_5000, m[0], p[2:0], 1'b0);
        run_req(32'h0000_BEE0, 1'b0, 3'b000, 1'b1);
        run_req(32'h0000_CAF0, 1'b1, 3'b000, 1'b1);
        run_req(32'h0000_D0D0, 1'b1, 3'b100, 1'b1);
        for (int j = 0; j < 14; j++)
            run_req(32'h0080_0000 + j * 32'h80, 1'b1, 3'b000, 1'b0);
        summary();
    end
endmodule